// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Controller

This block is the programmable front end of a single bus-master DMA channel that works next to a storage bus core. Software programs a start byte count, a start memory address and a start descriptor address, then writes a command. A start command copies the three start values into working registers, clears the status and enables the channel toward the core. An idle command disables the channel. An abort command sends a one-cycle cancel pulse to the core. A flush command is stored and does nothing else.

While the channel runs, the data path asks for chunks with a valid, a length and a direction. In the same cycle the controller returns the granted length, which is the request clamped to the bytes still owed, and the current working address. On the next clock edge it lowers the count and advances the address. Status records done, error and abort events and merges the core's live interrupt flag into every status read. A mode input selects how software clears the event bits: either a status read clears them, or a status write clears the bits where it carries a one.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset the command, start count, start address, start descriptor, working count and status registers read 0, the working address reads 0xFFFFFFFF, the working descriptor reads 0xFFFFFFFD, and dmaEnable and cancelPulse are low.
- R2: Register indices are 0 command, 1 start count, 2 start address, 3 working count, 4 working address, 5 status, 6 start descriptor, 7 working descriptor. Indices 0, 1, 2 and 6 read back the last full 32-bit value written. Writes to indices 3, 4 and 7 change nothing.
- R3: Command bits [1:0] pick the operation: 3 start, 0 idle, 2 abort, 1 flush. A start write loads working count, address and descriptor from their start registers, clears status bits [5:0] and raises dmaEnable from the next cycle. An idle write lowers dmaEnable. A flush write only updates the stored command.
- R4: A status read returns bit 4 set whenever coreIntFlag is high in that cycle.
- R5: A chunk is accepted when chunkValid is high and chunkToMem equals command bit 7 (1 = device to memory). Within that cycle chunkGrantLen is min(chunkLen, working count) and chunkAddr is the working address. At the next edge the working count drops and the working address rises by the grant. If the count reaches zero, status bit 3 (done) is set.
- R6: A chunk whose direction differs from command bit 7 is refused. chunkAccept is low, chunkGrantLen is 0, the count and address are unchanged, and status bit 1 (error) is set.
- R7: With w1cMode high, a status write clears each of bits 1, 2 and 3 where the written value has a one, and status reads clear nothing. With w1cMode low, a status read returns the current value and bits 1 to 3 are cleared at that edge, and status writes change nothing.
- R8: A command write with bits [1:0] = 2 raises cancelPulse in the following cycle.
- R9: coreCmdDone forces the working count to 0 and sets done at the next edge.
- R10: An event that sets done or error wins over a clear (read or write) in the same cycle. A start in the same cycle as a chunk or a core completion wins over both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (needed for clear on read) |
| regAddr | input | 3 | Register index |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, combinational from regAddr |
| w1cMode | input | 1 | 1 = write-one-to-clear, 0 = clear-on-read status |
| coreIntFlag | input | 1 | Live interrupt flag from the storage bus core |
| coreCmdDone | input | 1 | One-cycle command-completion strobe from the core |
| chunkValid | input | 1 | Chunk request valid |
| chunkToMem | input | 1 | Chunk direction, 1 = device to memory |
| chunkLen | input | 32 | Requested chunk length in bytes |
| chunkAccept | output | 1 | Chunk accepted this cycle |
| chunkGrantLen | output | 32 | Granted length, 0 when not accepted |
| chunkAddr | output | 32 | Memory address for the chunk |
| dmaEnable | output | 1 | Channel enabled toward the core |
| cancelPulse | output | 1 | One-cycle request cancel to the core |

## Verification
The status register is the point where functions collide. In one cycle a chunk can finish the count or the core can report completion, while software reads status in clear-on-read mode or writes ones to it in write-one-to-clear mode. The bench provokes these collisions with directed cycles that line up a final chunk with a status read, and a completion with a W1C write of the done bit. It also lets random traffic overlap them freely. It judges each case against a cycle model in which setting beats clearing: the colliding read shows the old value and the next read shows done. A start written in the same cycle as a chunk is checked the same way, and the reload must win.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int REG_W = 32;
  localparam int IDX_W = 3;
  localparam int ST_W  = 6;

  localparam logic [IDX_W-1:0] IDX_CMD   = 3'd0;
  localparam logic [IDX_W-1:0] IDX_SCNT  = 3'd1;
  localparam logic [IDX_W-1:0] IDX_SADDR = 3'd2;
  localparam logic [IDX_W-1:0] IDX_WCNT  = 3'd3;
  localparam logic [IDX_W-1:0] IDX_WADDR = 3'd4;
  localparam logic [IDX_W-1:0] IDX_STAT  = 3'd5;
  localparam logic [IDX_W-1:0] IDX_SDESC = 3'd6;
  localparam logic [IDX_W-1:0] IDX_WDESC = 3'd7;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_FLUSH = 2'd1,
    OP_ABORT = 2'd2,
    OP_START = 2'd3
  } cmdOp_e;

  localparam int CMD_DIR_BIT = 7;
  localparam int ST_ERR  = 1;
  localparam int ST_DONE = 3;
  localparam int ST_CINT = 4;
  localparam logic [ST_W-1:0] ST_EVT_MASK = 6'b001110;

  typedef struct packed {
    logic loadStart;
    logic wrCmd;
    logic wrStartCnt;
    logic wrStartAddr;
    logic wrStartDesc;
    logic statW1c;
    logic statCor;
    logic chunkTake;
    logic chunkReject;
    logic forceDone;
  } dpStrobe_t;
endpackage

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
  import dma_chan_pkg::*;
#(
  parameter int IDX_W_P = IDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [IDX_W_P-1:0] regAddr,
  input  logic [1:0]         opField,
  input  logic               w1cMode,
  input  logic               chunkValid,
  input  logic               chunkToMem,
  input  logic               cmdDir,
  input  logic               coreCmdDone,
  output dpStrobe_t          stb,
  output logic               dmaEnable,
  output logic               cancelPulse
);
  cmdOp_e op;
  logic   dirMatch;

  assign op       = cmdOp_e'(opField);
  assign dirMatch = (chunkToMem == cmdDir);

  always_comb begin
    stb             = '0;
    stb.wrCmd       = regWrEn && (regAddr == IDX_CMD);
    stb.loadStart   = stb.wrCmd && (op == OP_START);
    stb.wrStartCnt  = regWrEn && (regAddr == IDX_SCNT);
    stb.wrStartAddr = regWrEn && (regAddr == IDX_SADDR);
    stb.wrStartDesc = regWrEn && (regAddr == IDX_SDESC);
    stb.statW1c     = regWrEn && (regAddr == IDX_STAT) && w1cMode;
    stb.statCor     = regRdEn && (regAddr == IDX_STAT) && !w1cMode;
    stb.chunkTake   = chunkValid && dirMatch;
    stb.chunkReject = chunkValid && !dirMatch;
    stb.forceDone   = coreCmdDone;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dmaEnable   <= 1'b0;
      cancelPulse <= 1'b0;
    end else begin
      cancelPulse <= stb.wrCmd && (op == OP_ABORT);
      if (stb.loadStart)
        dmaEnable <= 1'b1;
      else if (stb.wrCmd && (op == OP_IDLE))
        dmaEnable <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_chan_dp.sv
module dma_chan_dp
  import dma_chan_pkg::*;
#(
  parameter int DATA_W  = REG_W,
  parameter int IDX_W_P = IDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  dpStrobe_t          stb,
  input  logic [IDX_W_P-1:0] regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  input  logic [DATA_W-1:0]  chunkLen,
  input  logic               coreIntFlag,
  output logic [DATA_W-1:0]  regRdData,
  output logic [DATA_W-1:0]  chunkGrantLen,
  output logic [DATA_W-1:0]  chunkAddr,
  output logic [DATA_W-1:0]  cmdQ,
  output logic [DATA_W-1:0]  workCntQ,
  output logic [ST_W-1:0]    statQ
);
  localparam logic [DATA_W-1:0] WADDR_RST = '1;
  localparam logic [DATA_W-1:0] WDESC_RST = ~DATA_W'(2);

  logic [DATA_W-1:0] sCntQ, sAddrQ, sDescQ, wAddrQ, wDescQ;
  logic [DATA_W-1:0] cmdN, sCntN, sAddrN, sDescN, wCntN, wAddrN, wDescN;
  logic [ST_W-1:0]   statN, statView;

  assign chunkGrantLen = !stb.chunkTake ? '0 :
                         (chunkLen < workCntQ) ? chunkLen : workCntQ;
  assign chunkAddr = wAddrQ;

  always_comb begin
    statView = statQ;
    statView[ST_CINT] = statQ[ST_CINT] | coreIntFlag;
  end

  always_comb begin
    unique case (regAddr)
      IDX_CMD:   regRdData = cmdQ;
      IDX_SCNT:  regRdData = sCntQ;
      IDX_SADDR: regRdData = sAddrQ;
      IDX_WCNT:  regRdData = workCntQ;
      IDX_WADDR: regRdData = wAddrQ;
      IDX_STAT:  regRdData = DATA_W'(statView);
      IDX_SDESC: regRdData = sDescQ;
      default:   regRdData = wDescQ;
    endcase
  end

  always_comb begin
    cmdN   = stb.wrCmd       ? regWrData : cmdQ;
    sCntN  = stb.wrStartCnt  ? regWrData : sCntQ;
    sAddrN = stb.wrStartAddr ? regWrData : sAddrQ;
    sDescN = stb.wrStartDesc ? regWrData : sDescQ;
    wCntN  = workCntQ;
    wAddrN = wAddrQ;
    wDescN = wDescQ;
    statN  = statQ;
    if (stb.statCor) statN = statN & ~ST_EVT_MASK;
    if (stb.statW1c) statN = statN & ~(regWrData[ST_W-1:0] & ST_EVT_MASK);
    if (stb.chunkTake) begin
      wCntN  = workCntQ - chunkGrantLen;
      wAddrN = wAddrQ + chunkGrantLen;
      if (wCntN == '0) statN[ST_DONE] = 1'b1;
    end
    if (stb.chunkReject) statN[ST_ERR] = 1'b1;
    if (stb.forceDone) begin
      wCntN = '0;
      statN[ST_DONE] = 1'b1;
    end
    if (stb.loadStart) begin
      wCntN  = sCntQ;
      wAddrN = sAddrQ;
      wDescN = sDescQ;
      statN  = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmdQ     <= '0;
      sCntQ    <= '0;
      sAddrQ   <= '0;
      sDescQ   <= '0;
      workCntQ <= '0;
      wAddrQ   <= WADDR_RST;
      wDescQ   <= WDESC_RST;
      statQ    <= '0;
    end else begin
      cmdQ     <= cmdN;
      sCntQ    <= sCntN;
      sAddrQ   <= sAddrN;
      sDescQ   <= sDescN;
      workCntQ <= wCntN;
      wAddrQ   <= wAddrN;
      wDescQ   <= wDescN;
      statQ    <= statN;
    end
  end
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
#(
  parameter int DATA_W  = REG_W,
  parameter int IDX_W_P = IDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [IDX_W_P-1:0] regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  input  logic               w1cMode,
  input  logic               coreIntFlag,
  input  logic               coreCmdDone,
  input  logic               chunkValid,
  input  logic               chunkToMem,
  input  logic [DATA_W-1:0]  chunkLen,
  output logic               chunkAccept,
  output logic [DATA_W-1:0]  chunkGrantLen,
  output logic [DATA_W-1:0]  chunkAddr,
  output logic               dmaEnable,
  output logic               cancelPulse
);
  dpStrobe_t         stb;
  logic [DATA_W-1:0] cmdQ;
  logic [DATA_W-1:0] workCntQ;
  logic [ST_W-1:0]   statQ;

  dma_chan_ctl #(.IDX_W_P(IDX_W_P)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .opField(regWrData[1:0]), .w1cMode(w1cMode),
    .chunkValid(chunkValid), .chunkToMem(chunkToMem),
    .cmdDir(cmdQ[CMD_DIR_BIT]), .coreCmdDone(coreCmdDone),
    .stb(stb), .dmaEnable(dmaEnable), .cancelPulse(cancelPulse)
  );

  dma_chan_dp #(.DATA_W(DATA_W), .IDX_W_P(IDX_W_P)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb),
    .regAddr(regAddr), .regWrData(regWrData), .chunkLen(chunkLen),
    .coreIntFlag(coreIntFlag), .regRdData(regRdData),
    .chunkGrantLen(chunkGrantLen), .chunkAddr(chunkAddr),
    .cmdQ(cmdQ), .workCntQ(workCntQ), .statQ(statQ)
  );

  assign chunkAccept = stb.chunkTake;
endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              regWrEn,
  input logic              regRdEn,
  input logic [2:0]        regAddr,
  input logic [DATA_W-1:0] regWrData,
  input logic [DATA_W-1:0] regRdData,
  input logic              coreIntFlag,
  input logic              coreCmdDone,
  input logic              chunkValid,
  input logic              chunkToMem,
  input logic [DATA_W-1:0] chunkLen,
  input logic              chunkAccept,
  input logic [DATA_W-1:0] chunkGrantLen,
  input logic              dmaEnable,
  input logic              cancelPulse,
  input logic [DATA_W-1:0] cmdQ,
  input logic [DATA_W-1:0] workCntQ,
  input logic [5:0]        statQ
);
  logic isStart, isAbort;
  assign isStart = regWrEn && (regAddr == 3'd0) && (regWrData[1:0] == 2'b11);
  assign isAbort = regWrEn && (regAddr == 3'd0) && (regWrData[1:0] == 2'b10);

  assert_grant_clamp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    chunkAccept |-> (chunkGrantLen <= workCntQ) && (chunkGrantLen <= chunkLen));

  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (chunkAccept && !isStart && !coreCmdDone) |=>
      (workCntQ == $past(workCntQ) - $past(chunkGrantLen)));

  assert_wrong_dir_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (chunkValid && (chunkToMem != cmdQ[7])) |-> (!chunkAccept && (chunkGrantLen == '0)));

  assert_start_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    isStart |=> (dmaEnable && (statQ == 6'd0)));

  assert_int_merge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (regRdEn && (regAddr == 3'd5) && coreIntFlag) |-> regRdData[4]);

  assert_cancel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    isAbort |=> cancelPulse);

  assert_core_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (coreCmdDone && !isStart) |=> ((workCntQ == '0) && statQ[3]));

  assert_done_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (chunkAccept && (chunkGrantLen == workCntQ) && !isStart) |=> statQ[3]);
endmodule

bind dma_chan_ctrl dma_chan_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regRdEn(regRdEn),
  .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
  .coreIntFlag(coreIntFlag), .coreCmdDone(coreCmdDone),
  .chunkValid(chunkValid), .chunkToMem(chunkToMem), .chunkLen(chunkLen),
  .chunkAccept(chunkAccept), .chunkGrantLen(chunkGrantLen),
  .dmaEnable(dmaEnable), .cancelPulse(cancelPulse),
  .cmdQ(cmdQ), .workCntQ(workCntQ), .statQ(statQ)
);

// File: tb/dma_chan_ctrl_bench.sv
`timescale 1ns/1ps
module dma_chan_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        regWrEn = 0, regRdEn = 0, w1cMode = 0, coreIntFlag = 0, coreCmdDone = 0;
  logic        chunkValid = 0, chunkToMem = 0;
  logic [2:0]  regAddr = 0;
  logic [31:0] regWrData = 0, chunkLen = 0;
  logic [31:0] regRdData, chunkGrantLen, chunkAddr;
  logic        chunkAccept, dmaEnable, cancelPulse;

  int nChecks = 0, nErrors = 0;
  bit finished = 0;

  logic [31:0] mCmd, mSCnt, mSAddr, mSDesc, mWCnt, mWAddr, mWDesc;
  logic [5:0]  mStat;
  logic        mEn, mCancel;

  always #10 clk = ~clk;

  dma_chan_ctrl u_dma_chan_ctrl (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .w1cMode(w1cMode), .coreIntFlag(coreIntFlag), .coreCmdDone(coreCmdDone),
    .chunkValid(chunkValid), .chunkToMem(chunkToMem), .chunkLen(chunkLen),
    .chunkAccept(chunkAccept), .chunkGrantLen(chunkGrantLen), .chunkAddr(chunkAddr),
    .dmaEnable(dmaEnable), .cancelPulse(cancelPulse)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s at %0t: actual 0x%08h expected 0x%08h", tag, $time, act, exp);
    end
  endtask

  function automatic logic [31:0] modelRead(input logic [2:0] a, input logic cint);
    case (a)
      3'd0: return mCmd;
      3'd1: return mSCnt;
      3'd2: return mSAddr;
      3'd3: return mWCnt;
      3'd4: return mWAddr;
      3'd5: return {26'd0, mStat | {1'b0, cint, 4'b0}};
      3'd6: return mSDesc;
      default: return mWDesc;
    endcase
  endfunction

  task automatic modelReset();
    mCmd = 0; mSCnt = 0; mSAddr = 0; mSDesc = 0; mWCnt = 0;
    mWAddr = 32'hFFFF_FFFF; mWDesc = 32'hFFFF_FFFD; mStat = 0; mEn = 0; mCancel = 0;
  endtask

  // One clock cycle: drive, check combinational answers, then check registered results.
  task automatic step(input logic wr, input logic rd, input logic [2:0] a, input logic [31:0] wd,
                      input logic w1c, input logic cv, input logic dir, input logic [31:0] len,
                      input logic cdone, input logic cint, input string rdTag);
    logic acc; logic [31:0] g, nCnt, nAddr; logic [5:0] nStat; bit isCmd;
    @(negedge clk);
    regWrEn = wr; regRdEn = rd; regAddr = a; regWrData = wd; w1cMode = w1c;
    chunkValid = cv; chunkToMem = dir; chunkLen = len; coreCmdDone = cdone; coreIntFlag = cint;
    #1;
    acc = cv && (dir == mCmd[7]);
    g = !acc ? 32'd0 : ((len < mWCnt) ? len : mWCnt);
    check(chunkAccept == acc, (cv && !acc) ? "R6" : "R5", {31'd0, chunkAccept}, {31'd0, acc});
    check(chunkGrantLen == g, (cv && !acc) ? "R6" : "R5", chunkGrantLen, g);
    if (acc) check(chunkAddr == mWAddr, "R5", chunkAddr, mWAddr);
    if (rd) check(regRdData == modelRead(a, cint), rdTag, regRdData, modelRead(a, cint));
    // next state from the requirements
    nCnt = mWCnt; nAddr = mWAddr; nStat = mStat;
    if (rd && a == 3'd5 && !w1c) nStat &= ~6'b001110;
    if (wr && a == 3'd5 && w1c)  nStat &= ~(wd[5:0] & 6'b001110);
    if (acc) begin
      nCnt = mWCnt - g; nAddr = mWAddr + g;
      if (nCnt == 0) nStat[3] = 1'b1;
    end
    if (cv && !acc) nStat[1] = 1'b1;
    if (cdone) begin nCnt = 0; nStat[3] = 1'b1; end
    isCmd = wr && (a == 3'd0);
    mCancel = isCmd && (wd[1:0] == 2'd2);
    if (isCmd && wd[1:0] == 2'd3) begin
      nCnt = mSCnt; nAddr = mSAddr; mWDesc = mSDesc; nStat = 0; mEn = 1;
    end
    if (isCmd && wd[1:0] == 2'd0) mEn = 0;
    if (isCmd) mCmd = wd;
    if (wr && a == 3'd1) mSCnt = wd;
    if (wr && a == 3'd2) mSAddr = wd;
    if (wr && a == 3'd6) mSDesc = wd;
    mWCnt = nCnt; mWAddr = nAddr; mStat = nStat;
    @(posedge clk); #1;
    check(dmaEnable == mEn, "R3", {31'd0, dmaEnable}, {31'd0, mEn});
    check(cancelPulse == mCancel, "R8", {31'd0, cancelPulse}, {31'd0, mCancel});
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [31:0] d, input logic w1c);
    step(1, 0, a, d, w1c, 0, 0, 0, 0, 0, "R2");
  endtask
  task automatic rdReg(input logic [2:0] a, input logic w1c, input logic cint, input string tag);
    step(0, 1, a, 0, w1c, 0, 0, 0, 0, cint, tag);
  endtask
  task automatic chunk(input logic dir, input logic [31:0] len, input string tag);
    step(0, 0, 0, 0, 0, 1, dir, len, 0, 0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nErrors++;
      $display("FAIL R1 watchdog expired: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    modelReset();
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    #1; rst_n = 1'b1;
    check(dmaEnable == 0 && cancelPulse == 0, "R1", {30'd0, dmaEnable, cancelPulse}, 0);
    for (int i = 0; i < 8; i++) rdReg(3'(i), 1'b1, 1'b0, "R1");

    // R2 map and writability
    wrReg(1, 32'h40, 0); wrReg(2, 32'h1000, 0); wrReg(6, 32'hABC0, 0);
    wrReg(3, 32'h1234_5678, 0); wrReg(4, 32'h9, 0); wrReg(7, 32'h77, 0);
    for (int i = 0; i < 8; i++) rdReg(3'(i), 1'b1, 1'b0, "R2");

    // R3 start toward memory, then R5 chunks with clamp and done
    wrReg(0, 32'h83, 0);
    rdReg(3, 1, 0, "R3"); rdReg(4, 1, 0, "R3"); rdReg(7, 1, 0, "R3");
    chunk(1, 32'h10, "R5"); chunk(1, 32'h0, "R5"); chunk(1, 32'h100, "R5");
    rdReg(4, 1, 0, "R5");
    rdReg(5, 0, 0, "R7"); rdReg(5, 0, 0, "R7");
    // R6 wrong direction
    chunk(0, 32'h8, "R6");
    rdReg(5, 1, 0, "R6");
    // R3 flush command keeps state
    wrReg(0, 32'h81, 0); rdReg(0, 1, 0, "R3"); rdReg(5, 1, 0, "R3");
    // R7 W1C and R9 completion
    wrReg(0, 32'h83, 1);
    step(0, 0, 0, 0, 1, 0, 0, 0, 1, 0, "R9");
    rdReg(3, 1, 0, "R9"); rdReg(5, 1, 0, "R7"); rdReg(5, 1, 0, "R7");
    wrReg(5, 32'h2, 1); rdReg(5, 1, 0, "R7");
    wrReg(5, 32'h8, 0); rdReg(5, 1, 0, "R7");
    wrReg(5, 32'h8, 1); rdReg(5, 1, 0, "R7");
    // R4 interrupt merge
    rdReg(5, 1, 1, "R4");
    // R8 abort then idle
    wrReg(0, 32'h82, 0); wrReg(0, 32'h80, 0);
    // R10 collisions
    wrReg(1, 32'h4, 0); wrReg(0, 32'h83, 0);
    step(0, 1, 5, 0, 0, 1, 1, 32'h4, 0, 0, "R10");
    rdReg(5, 0, 0, "R10");
    step(1, 0, 5, 32'h8, 1, 0, 0, 0, 1, 0, "R10");
    rdReg(5, 1, 0, "R10");
    step(1, 0, 0, 32'h83, 0, 1, 1, 32'h2, 1, 0, "R10");
    rdReg(3, 1, 0, "R10"); rdReg(5, 1, 0, "R10");

    // random traffic
    for (int i = 0; i < 600; i++) begin
      int k; logic [2:0] a; logic [31:0] wd; logic wr, rd;
      k  = $urandom_range(0, 9);
      a  = 3'($urandom_range(0, 7));
      wr = (k < 3);
      rd = $urandom_range(0, 1) == 1;
      wd = $urandom;
      if (wr && a == 3'd1) wd = $urandom_range(0, 300);
      if (wr && a == 3'd0 && $urandom_range(0, 1) == 1) wd[1:0] = 2'b11;
      step(wr, rd, a, wd, $urandom_range(0, 1) == 1, k >= 5, $urandom_range(0, 1) == 1,
           $urandom_range(0, 80), $urandom_range(0, 30) == 0, $urandom_range(0, 1) == 1,
           (a == 3'd5) ? "R7" : "R2");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule